// File: doc/BRIEF.md
# Dual-Path Register Access Bridge

This block is a bus slave. It gives a host two ways to reach a bank of 16-bit registers. Inside the block, every register is named by a 16-bit word index. In the direct path, a short byte-addressed region of the host bus maps the low indices onto the bus. The byte offset of a register is twice its word index. In the windowed path, the host first stores a target index in a window index register at byte offset 0. It then moves data through a window data port at byte offset 2. The stored index stays in place until the host overwrites it. Any number of data accesses can therefore follow a single index write.

Each word index can hold two unrelated registers. The first is a write-side control register, which the block stores and drives out on `ctrl_o`. The second is a read-side status value, which comes in on `sts_i`. A write to an index updates the control register, and a read from the same index returns the status value. Indices 0 and 1 are taken by the window index register and the window data port. Bank storage therefore starts at index 2. Slot k of `ctrl_o` and `sts_i` (bits k*16 to k*16+15) belongs to index k+2.

The host bus has no back-pressure. Each strobe is accepted in the cycle it is sampled, so the bus behaves as a handshake whose ready is always high. A read returns its data in the same cycle as the read strobe. A write takes effect at the next rising clock edge. If read and write are strobed together, the read returns the value from before the write.

Top module: `wbr_bridge`

## Requirements
- R1: After reset the window index register reads 0 and every control register on `ctrl_o` is 0.
- R2: A write to byte offset 0 loads `bus_wdata` into the window index register, and a read at byte offset 0 returns the stored index in the same cycle.
- R3: A write to byte offset 2 stores `bus_wdata` into the control register at the stored window index; the register changes at that clock edge.
- R4: A read at byte offset 2 returns, in the same cycle, the status value at the stored window index.
- R5: The window index is kept across any number of data-port accesses; only a write to byte offset 0 changes it.
- R6: For word index k from 2 to DIRECT_WORDS-1 (2 to 7 by default), byte offset 2k reaches index k directly: writes store into control register k and reads return status value k.
- R7: Write and read sides of one index are separate: reading an index returns its status input, never the value last written there.
- R8: Byte offsets at or above 2*DIRECT_WORDS (16 by default) read as 0 and writes there change nothing; indices from DIRECT_WORDS upward are reachable only through the window.
- R9: Odd byte offsets read as 0 and writes there change nothing.
- R10: Indices with no register read as 0 and drop writes. Write-side registers exist for indices 2 to NUM_WR-1 (15); read-side values exist for indices 2 to NUM_RD-1 (19). Indices 0 and 1 reached through the window have no register on either side.
- R11: A direct access and a windowed access to the same index give identical results, both for reads and for writes.
- R12: `bus_rdata` is 0 in every cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Host byte address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when no read is strobed |
| sts_i | input | (NUM_RD-2)*16 | Read-side status values, slot k for index k+2 |
| ctrl_o | output | (NUM_WR-2)*16 | Write-side control registers, slot k for index k+2 |

## Verification
Several properties are checked by the assertions on every cycle:
- a window index load captures the bus data;
- the index holds unless byte offset 0 is written;
- the control registers never move without a write strobe;
- writes to odd or out-of-range offsets leave every register unchanged;
- read data is 0 while idle, and a read at offset 0 mirrors the index.

Other behaviour can only be shown by the bench's scenarios. This covers whether a data-port access hits the right slot and whether reads return the status side rather than the control side. It also covers unimplemented indices reached through the window, and the cross-check in which direct and windowed accesses to indices 2 to 7 must agree.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int WORD_W    = 16;
  // first word index backed by bank storage; 0 and 1 are the window pair
  localparam int BANK_BASE = 2;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_WADDR = 2'd1,
    TGT_BANK  = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [WORD_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/wbr_route.sv
module wbr_route import wbr_pkg::*; #(
  parameter int ADDR_W       = 5,
  parameter int DIRECT_WORDS = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] win_idx,
  output route_t            route
);
  localparam int WORD_AW = ADDR_W - 1;

  logic [WORD_AW-1:0] word;
  assign word = bus_addr[ADDR_W-1:1];

  always_comb begin
    route.tgt = TGT_NONE;
    route.idx = '0;
    if (!bus_addr[0]) begin
      if (word == '0) begin
        route.tgt = TGT_WADDR;
      end else if (word == WORD_AW'(1)) begin
        route.tgt = TGT_BANK;
        route.idx = win_idx;
      end else if (int'(word) < DIRECT_WORDS) begin
        route.tgt = TGT_BANK;
        route.idx = WORD_W'(word);
      end
    end
  end
endmodule

// File: rtl/wbr_winreg.sv
module wbr_winreg import wbr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/wbr_bank.sv
module wbr_bank import wbr_pkg::*; #(
  parameter int NUM_WR = 16,
  parameter int NUM_RD = 20
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [WORD_W-1:0]                  idx,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic [(NUM_RD-BANK_BASE)*WORD_W-1:0] sts_i,
  output logic [(NUM_WR-BANK_BASE)*WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0]                  rd_val
);
  // write side: one register per implemented index
  for (genvar g = BANK_BASE; g < NUM_WR; g++) begin : g_wr
    localparam int SLOT = g - BANK_BASE;
    logic              hit;
    logic [WORD_W-1:0] q;
    assign hit = wr_en && (idx == WORD_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign ctrl_o[SLOT*WORD_W +: WORD_W] = q;
  end

  // read side: status mux, zero outside the implemented range
  always_comb begin
    rd_val = '0;
    for (int i = BANK_BASE; i < NUM_RD; i++) begin
      if (idx == WORD_W'(i)) rd_val = sts_i[(i-BANK_BASE)*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/wbr_bridge.sv
module wbr_bridge import wbr_pkg::*; #(
  parameter int ADDR_W       = 5,
  parameter int NUM_WR       = 16,
  parameter int NUM_RD       = 20,
  parameter int DIRECT_WORDS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic                                bus_wr,
  input  logic                                bus_rd,
  input  logic [15:0]                         bus_wdata,
  output logic [15:0]                         bus_rdata,
  input  logic [(NUM_RD-BANK_BASE)*16-1:0]    sts_i,
  output logic [(NUM_WR-BANK_BASE)*16-1:0]    ctrl_o
);
  route_t            rt;
  logic [WORD_W-1:0] win_q;
  logic [WORD_W-1:0] bank_rd;
  logic              load_win;
  logic              bank_wr;

  wbr_route #(.ADDR_W(ADDR_W), .DIRECT_WORDS(DIRECT_WORDS)) u_route (
    .bus_addr (bus_addr),
    .win_idx  (win_q),
    .route    (rt)
  );

  assign load_win = bus_wr && (rt.tgt == TGT_WADDR);
  assign bank_wr  = bus_wr && (rt.tgt == TGT_BANK);

  wbr_winreg u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_win),
    .d     (bus_wdata),
    .q     (win_q)
  );

  wbr_bank #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr),
    .idx     (rt.idx),
    .wr_data (bus_wdata),
    .sts_i   (sts_i),
    .ctrl_o  (ctrl_o),
    .rd_val  (bank_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (rt.tgt)
        TGT_WADDR: bus_rdata = win_q;
        TGT_BANK:  bus_rdata = bank_rd;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wbr_bridge_chk.sv
module wbr_bridge_chk #(
  parameter int ADDR_W       = 5,
  parameter int NUM_WR       = 16,
  parameter int DIRECT_WORDS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [15:0]             bus_wdata,
  input logic [15:0]             bus_rdata,
  input logic [(NUM_WR-2)*16-1:0] ctrl_o,
  input logic [15:0]             win_q
);
  logic wr_idx_port;
  logic wr_out_range;
  assign wr_idx_port  = bus_wr && (bus_addr == '0);
  assign wr_out_range = bus_wr && (int'(bus_addr[ADDR_W-1:1]) >= DIRECT_WORDS);

  a_r2_win_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_port |=> win_q == $past(bus_wdata));

  a_r5_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_idx_port |=> $stable(win_q));

  a_r2_win_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |-> bus_rdata == win_q);

  a_r3_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctrl_o));

  a_r9_odd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |=> ($stable(ctrl_o) && $stable(win_q)));

  a_r8_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_range |=> ($stable(ctrl_o) && $stable(win_q)));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind wbr_bridge wbr_bridge_chk #(
  .ADDR_W(ADDR_W), .NUM_WR(NUM_WR), .DIRECT_WORDS(DIRECT_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ctrl_o(ctrl_o), .win_q(win_q)
);

// File: tb/wbr_bridge_tb.sv
module wbr_bridge_tb;
  localparam int ADDR_W = 5, NUM_WR = 16, NUM_RD = 20, DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [(NUM_RD-2)*16-1:0] sts_i;
  logic [(NUM_WR-2)*16-1:0] ctrl_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wbr_bridge #(.ADDR_W(ADDR_W), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DIRECT_WORDS(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_i(sts_i), .ctrl_o(ctrl_o));

  function automatic logic [15:0] sts_val(int k);
    return 16'(16'hC000 + k * 16'h0111);
  endfunction

  initial begin
    for (int k = 2; k < NUM_RD; k++) sts_i[(k-2)*16 +: 16] = sts_val(k);
  end

  function automatic logic [15:0] ctrl_at(int k);
    return ctrl_o[(k-2)*16 +: 16];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(int addr, logic [15:0] data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int addr, output logic [15:0] data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
    #2 data = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(0, d);
    check("R1 window index after reset", d, 16'h0);
    check("R1 control regs after reset", 16'(ctrl_o != '0), 16'h0);
  endtask

  task automatic t_window_index();
    logic [15:0] d;
    bus_write(0, 16'd5);
    bus_read(0, d);
    check("R2 index readback", d, 16'd5);
  endtask

  task automatic t_win_write();
    bus_write(0, 16'd9);
    bus_write(2, 16'h1234);
    check("R3 windowed write idx9", ctrl_at(9), 16'h1234);
    check("R8 idx9 via window only", ctrl_at(9), 16'h1234);
  endtask

  task automatic t_win_read();
    logic [15:0] d;
    bus_write(0, 16'd17);
    bus_read(2, d);
    check("R4 windowed read idx17", d, sts_val(17));
  endtask

  task automatic t_persist();
    logic [15:0] d;
    bus_write(0, 16'd10);
    bus_write(2, 16'h1111);
    bus_write(2, 16'h2222);
    bus_read(2, d);
    check("R5 second write same target", ctrl_at(10), 16'h2222);
    check("R5 read same target", d, sts_val(10));
    bus_read(0, d);
    check("R5 index kept", d, 16'd10);
  endtask

  task automatic t_direct();
    logic [15:0] d;
    for (int k = 2; k < DW; k++) begin
      bus_write(2*k, 16'(16'h0100 + k));
      check("R6 direct write", ctrl_at(k), 16'(16'h0100 + k));
      bus_read(2*k, d);
      check("R6 direct read", d, sts_val(k));
    end
  endtask

  task automatic t_split();
    logic [15:0] d;
    bus_write(0, 16'd4);
    bus_write(2, 16'hBEEF);
    bus_read(2, d);
    check("R7 read side separate", d, sts_val(4));
    check("R7 write side held", ctrl_at(4), 16'hBEEF);
  endtask

  task automatic t_high();
    logic [15:0] d;
    logic [(NUM_WR-2)*16-1:0] snap;
    logic [15:0] widx;
    bus_read(0, widx);
    snap = ctrl_o;
    for (int a = 2*DW; a < 32; a += 2) begin
      bus_write(a, 16'hFFFF);
      bus_read(a, d);
      check("R8 high offset reads 0", d, 16'h0);
    end
    check("R8 high writes ignored", 16'(ctrl_o != snap), 16'h0);
    bus_read(0, d);
    check("R8 index untouched", d, widx);
  endtask

  task automatic t_odd();
    logic [15:0] d;
    logic [(NUM_WR-2)*16-1:0] snap;
    logic [15:0] widx;
    bus_read(0, widx);
    snap = ctrl_o;
    bus_write(1, 16'hAAAA);
    bus_write(5, 16'h5555);
    bus_read(3, d);
    check("R9 odd read 0", d, 16'h0);
    bus_read(5, d);
    check("R9 odd read 0 at 5", d, 16'h0);
    check("R9 odd writes ignored", 16'(ctrl_o != snap), 16'h0);
    bus_read(0, d);
    check("R9 index untouched", d, widx);
  endtask

  task automatic t_unimpl();
    logic [15:0] d;
    logic [(NUM_WR-2)*16-1:0] snap;
    snap = ctrl_o;
    bus_write(0, 16'd0);
    bus_write(2, 16'h7777);
    bus_read(2, d);
    check("R10 idx0 reads 0", d, 16'h0);
    bus_read(0, d);
    check("R10 idx0 write leaves index", d, 16'd0);
    bus_write(0, 16'd1);
    bus_write(2, 16'h7777);
    bus_read(2, d);
    check("R10 idx1 reads 0", d, 16'h0);
    bus_write(0, 16'(NUM_WR));
    bus_write(2, 16'h7777);
    check("R10 writes dropped", 16'(ctrl_o != snap), 16'h0);
    bus_read(2, d);
    check("R10 idx16 status present", d, sts_val(NUM_WR));
    bus_write(0, 16'(NUM_RD));
    bus_read(2, d);
    check("R10 idx20 reads 0", d, 16'h0);
    bus_write(0, 16'hFFFF);
    bus_read(2, d);
    check("R10 idxFFFF reads 0", d, 16'h0);
  endtask

  task automatic t_compare();
    logic [15:0] dd, dw;
    for (int k = 2; k < DW; k++) begin
      bus_read(2*k, dd);
      bus_write(0, 16'(k));
      bus_read(2, dw);
      check("R11 read paths agree", dw, dd);
      bus_write(2, 16'(16'h3000 + k));
      dw = ctrl_at(k);
      bus_write(2*k, 16'(16'h3000 + k));
      check("R11 write paths agree", ctrl_at(k), dw);
    end
  endtask

  task automatic t_idle();
    bus_write(0, 16'd6);
    @(negedge clk);
    bus_addr = '0; bus_rd = 1'b0;
    #2 check("R12 idle at index port", bus_rdata, 16'h0);
    bus_addr = ADDR_W'(4);
    #1 check("R12 idle at direct port", bus_rdata, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window_index();
    t_win_write();
    t_win_read();
    t_persist();
    t_direct();
    t_split();
    t_high();
    t_odd();
    t_unimpl();
    t_compare();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule